// File: doc/BRIEF.md
# Three-Level Space-Vector Switching Sequencer

This block turns one modulation period's worth of space-vector decisions into per-phase switch levels for a three-phase, three-level neutral-point-clamped inverter. Upstream logic supplies two dwell fractions, the two active vertex states, and a pair of redundant states that produce the same voltage vector. On each period strobe the block captures these inputs and turns the fractions into cycle counts. It then plays a mirrored sequence of eight segments: opening redundant state, first active state, second active state, closing redundant state, and the same four again in reverse order.

Each phase level is 0, 1 or 2. Because the sequence starts and ends on the two states of the redundant pair, a caller that supplies a valid sector neighbourhood sees only one phase change level at each transition. Segments with zero dwell are skipped. The outputs are the three phase levels and the index of the segment being played.

Top module: `sv_seq`

## Requirements
- R1: A switching state is 6 bits, with phase R in bits [5:4], phase Y in [3:2] and phase B in [1:0]. Segment indices 0..7 carry, in order: `vec_open`, `vec_a`, `vec_b`, `vec_close`, `vec_close`, `vec_b`, `vec_a`, `vec_open`. The index shown on `seg_idx` never decreases within a period.
- R2: With T = PERIOD_CYCLES and the fractions taken as unsigned Q1.15, the dwell of `vec_a` is dA = min(floor(T·frac_a/32768), T). The dwell of `vec_b` is dB = min(floor(T·frac_b/32768), T − dA). The redundant-vector dwell is d0 = T − dA − dB.
- R3: Segments 1 and 6 each last floor(dA/2) cycles. Segments 2 and 5 each last floor(dB/2). Segments 3, 4 and 7 each last floor(d0/4). Segment 0 takes the rest, so the eight lengths add up to exactly T.
- R4: A strobe sampled on a clock edge makes the first non-empty segment appear right after that edge. Each segment holds for exactly its length in cycles, and the segments follow one another with no gap.
- R5: A segment of zero length is never shown on the outputs.
- R6: Inputs are captured only at a strobe. Changes to fractions or states during a period have no effect on that period.
- R7: A strobe that arrives during a period abandons the current period and starts the new one at once.
- R8: After the last segment, with no new strobe, the outputs and `seg_idx` hold their final values.
- R9: After reset all three levels are 0 and `seg_idx` is 0.
- R10: When every segment is non-empty and the inputs are sector neighbours, exactly one phase level changes at each transition. The lengths and states of segments k and 7−k match for k = 1, 2, 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_go | input | 1 | Period start strobe; captures all other inputs |
| frac_a | input | 16 | Dwell fraction of `vec_a`, unsigned Q1.15 |
| frac_b | input | 16 | Dwell fraction of `vec_b`, unsigned Q1.15 |
| vec_open | input | 6 | Redundant state that opens and closes the period |
| vec_a | input | 6 | First active vertex state |
| vec_b | input | 6 | Second active vertex state |
| vec_close | input | 6 | Redundant state at the middle of the period |
| lvl_r | output | 2 | Level of phase R |
| lvl_y | output | 2 | Level of phase Y |
| lvl_b | output | 2 | Level of phase B |
| seg_idx | output | 3 | Index of the segment being played |

## Verification
The bench predicts every cycle of each period from its own dwell arithmetic. Its patterns include odd remainders, fractions that add to more than one, a zero active dwell and a zero redundant dwell.

- A design that rounded the split differently would lose or gain a cycle, and its period would differ from T.
- A design that failed to skip empty segments would show a segment index with no dwell.
- A design that captured inputs outside the strobe would change levels in the middle of a period, because the bench scrambles all inputs there.
- A design that ignored a strobe arriving mid-period would keep playing the old period.

The bench also checks that one phase changes per transition for sector-neighbour inputs, including a move into the adjacent sector. It checks that the outputs hold after the last segment.

// File: rtl/sv_seq_pkg.sv
`timescale 1ns/1ps
package sv_seq_pkg;
  localparam int LVL_W   = 2;
  localparam int PHASES  = 3;
  localparam int STATE_W = LVL_W * PHASES;
  localparam int NSEG    = 8;
  localparam int SEG_W   = $clog2(NSEG);

  typedef logic [STATE_W-1:0] vstate_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // which input state a segment index carries: 0 open, 1 a, 2 b, 3 close
  function automatic logic [1:0] slot_of(input seg_t s);
    case (s)
      3'd0, 3'd7: return 2'd0;
      3'd1, 3'd6: return 2'd1;
      3'd2, 3'd5: return 2'd2;
      default:    return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/sv_seq_dwell.sv
`timescale 1ns/1ps
module sv_seq_dwell #(
  parameter int PERIOD_CYCLES = 10000,
  parameter int FRAC_W        = 16,
  parameter int FRAC_Q        = 15,
  localparam int CW           = $clog2(PERIOD_CYCLES + 1)
) (
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  output logic [CW-1:0]     len_a,   // segments 1 and 6
  output logic [CW-1:0]     len_b,   // segments 2 and 5
  output logic [CW-1:0]     len_z,   // segments 3, 4 and 7
  output logic [CW-1:0]     len_f    // segment 0, absorbs remainder
);
  localparam int PW = CW + FRAC_W;
  localparam int XW = CW + 2;
  localparam logic [CW-1:0] T = CW'(PERIOD_CYCLES);

  // scaled dwell, saturated at a limit
  function automatic logic [CW-1:0] scale_dwell(input logic [FRAC_W-1:0] z,
                                                input logic [CW-1:0] lim);
    logic [PW-1:0] prod;
    prod = (PW'(PERIOD_CYCLES) * PW'(z)) >> FRAC_Q;
    if (prod > PW'(lim)) return lim;
    return prod[CW-1:0];
  endfunction

  logic [CW-1:0] dwell_a, dwell_b, dwell_z;
  logic [XW-1:0] used;

  always_comb begin
    dwell_a = scale_dwell(frac_a, T);
    dwell_b = scale_dwell(frac_b, T - dwell_a);
    dwell_z = T - dwell_a - dwell_b;
    len_a   = dwell_a >> 1;
    len_b   = dwell_b >> 1;
    len_z   = dwell_z >> 2;
    used    = (XW'(len_a) << 1) + (XW'(len_b) << 1) + XW'(len_z) * XW'(3);
    len_f   = CW'(XW'(PERIOD_CYCLES) - used);
  end
endmodule

// File: rtl/sv_seq_timer.sv
`timescale 1ns/1ps
module sv_seq_timer
  import sv_seq_pkg::*;
#(
  parameter int PERIOD_CYCLES = 10000,
  localparam int CW           = $clog2(PERIOD_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [CW-1:0] new_a,
  input  logic [CW-1:0] new_b,
  input  logic [CW-1:0] new_z,
  input  logic [CW-1:0] new_f,
  output seg_t          seg_q,
  output logic          run_q
);
  logic [CW-1:0] la_q, lb_q, lz_q, lf_q, cnt_q;

  function automatic logic [CW-1:0] len_at(input seg_t s, input logic [CW-1:0] a,
      input logic [CW-1:0] b, input logic [CW-1:0] z, input logic [CW-1:0] f);
    case (slot_of(s))
      2'd0:    return (s == 3'd0) ? f : z;
      2'd1:    return a;
      2'd2:    return b;
      default: return z;
    endcase
  endfunction

  // first non-empty segment at or after index 'from'; bit SEG_W is the hit flag
  function automatic logic [SEG_W:0] find_from(input int from, input logic [CW-1:0] a,
      input logic [CW-1:0] b, input logic [CW-1:0] z, input logic [CW-1:0] f);
    logic [SEG_W:0] r;
    r = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (!r[SEG_W] && i >= from && len_at(seg_t'(i), a, b, z, f) != '0)
        r = {1'b1, seg_t'(i)};
    end
    return r;
  endfunction

  logic [SEG_W:0] first_hit, next_hit;
  logic           seg_end, seg_adv, period_done;
  logic [CW-1:0]  cur_len;

  assign first_hit   = find_from(0, new_a, new_b, new_z, new_f);
  assign next_hit    = find_from(int'(seg_q) + 1, la_q, lb_q, lz_q, lf_q);
  assign cur_len     = len_at(seg_q, la_q, lb_q, lz_q, lf_q);
  assign seg_end     = run_q && (cnt_q == '0);
  assign seg_adv     = seg_end && next_hit[SEG_W];
  assign period_done = seg_end && !next_hit[SEG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q <= '0; cnt_q <= '0; run_q <= 1'b0;
      la_q <= '0; lb_q <= '0; lz_q <= '0; lf_q <= '0;
    end else if (go) begin
      la_q <= new_a; lb_q <= new_b; lz_q <= new_z; lf_q <= new_f;
      seg_q <= first_hit[SEG_W-1:0];
      cnt_q <= len_at(first_hit[SEG_W-1:0], new_a, new_b, new_z, new_f) - 1'b1;
      run_q <= 1'b1;
    end else if (seg_adv) begin
      seg_q <= next_hit[SEG_W-1:0];
      cnt_q <= len_at(next_hit[SEG_W-1:0], la_q, lb_q, lz_q, lf_q) - 1'b1;
    end else if (period_done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R4: remaining count stays inside the current segment
  p_cnt_in_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q < cur_len));
  // R5: the segment being played is never empty
  p_no_empty_seg_r5: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cur_len != '0));
  // R1: advancing moves forward in index
  p_seg_forward_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_adv && !go) |=> (seg_q > $past(seg_q)));
  // R8: once finished, index holds until the next strobe
  p_idle_index_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !go) |=> $stable(seg_q));
endmodule

// File: rtl/sv_seq_pick.sv
`timescale 1ns/1ps
module sv_seq_pick
  import sv_seq_pkg::*;
(
  input  seg_t    seg,
  input  vstate_t st_open,
  input  vstate_t st_a,
  input  vstate_t st_b,
  input  vstate_t st_close,
  output vstate_t st_out
);
  always_comb begin
    case (slot_of(seg))
      2'd0:    st_out = st_open;
      2'd1:    st_out = st_a;
      2'd2:    st_out = st_b;
      default: st_out = st_close;
    endcase
  end
endmodule

// File: rtl/sv_seq.sv
`timescale 1ns/1ps
module sv_seq
  import sv_seq_pkg::*;
#(
  parameter int PERIOD_CYCLES = 10000,
  parameter int FRAC_W        = 16,
  parameter int FRAC_Q        = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_go,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  input  logic [5:0]        vec_open,
  input  logic [5:0]        vec_a,
  input  logic [5:0]        vec_b,
  input  logic [5:0]        vec_close,
  output logic [1:0]        lvl_r,
  output logic [1:0]        lvl_y,
  output logic [1:0]        lvl_b,
  output logic [2:0]        seg_idx
);
  localparam int CW = $clog2(PERIOD_CYCLES + 1);

  logic [CW-1:0] n_a, n_b, n_z, n_f;
  vstate_t       so_q, sa_q, sb_q, sc_q, cur_st;
  seg_t          seg_q;
  logic          run_q;

  sv_seq_dwell #(.PERIOD_CYCLES(PERIOD_CYCLES), .FRAC_W(FRAC_W), .FRAC_Q(FRAC_Q)) u_dwell (
    .frac_a(frac_a), .frac_b(frac_b),
    .len_a(n_a), .len_b(n_b), .len_z(n_z), .len_f(n_f));

  sv_seq_timer #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .go(period_go),
    .new_a(n_a), .new_b(n_b), .new_z(n_z), .new_f(n_f),
    .seg_q(seg_q), .run_q(run_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      so_q <= '0; sa_q <= '0; sb_q <= '0; sc_q <= '0;
    end else if (period_go) begin
      so_q <= vec_open; sa_q <= vec_a; sb_q <= vec_b; sc_q <= vec_close;
    end
  end

  sv_seq_pick u_pick (
    .seg(seg_q), .st_open(so_q), .st_a(sa_q), .st_b(sb_q), .st_close(sc_q),
    .st_out(cur_st));

  assign lvl_r   = cur_st[5:4];
  assign lvl_y   = cur_st[3:2];
  assign lvl_b   = cur_st[1:0];
  assign seg_idx = seg_q;

  // R6: captured states move only on a strobe
  p_capture_on_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !period_go |=> $stable({so_q, sa_q, sb_q, sc_q}));
  // R8: levels hold once the period is over
  p_idle_levels_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !period_go) |=> $stable({lvl_r, lvl_y, lvl_b}));
  // R4: a strobe always starts a period
  p_go_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    period_go |=> run_q);
endmodule

// File: tb/tb_sv_seq.sv
`timescale 1ns/1ps
module tb_sv_seq;
  localparam int PER = 40;

  logic clk = 1'b0, rst_n = 1'b0, period_go = 1'b0;
  logic [15:0] frac_a = '0, frac_b = '0;
  logic [5:0]  vec_open = '0, vec_a = '0, vec_b = '0, vec_close = '0;
  logic [1:0]  lvl_r, lvl_y, lvl_b;
  logic [2:0]  seg_idx;

  int total = 0, bad = 0;
  int exp_seg[PER];
  logic [5:0] exp_st[PER];
  int obs_seg[PER];
  logic [5:0] obs_st[PER];
  int seg_len[8];

  always #2.5 clk = ~clk;

  sv_seq #(.PERIOD_CYCLES(PER)) dut (
    .clk(clk), .rst_n(rst_n), .period_go(period_go),
    .frac_a(frac_a), .frac_b(frac_b),
    .vec_open(vec_open), .vec_a(vec_a), .vec_b(vec_b), .vec_close(vec_close),
    .lvl_r(lvl_r), .lvl_y(lvl_y), .lvl_b(lvl_b), .seg_idx(seg_idx));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // expected timeline built from R2/R3 arithmetic (R2, R3)
  task automatic build_exp(input int za, input int zb, input logic [5:0] po,
                           input logic [5:0] pa, input logic [5:0] pb, input logic [5:0] pc);
    int da, db, dz, k;
    logic [5:0] which[8];
    da = (PER * za) / 32768; if (da > PER) da = PER;
    db = (PER * zb) / 32768; if (db > PER - da) db = PER - da;
    dz = PER - da - db;
    seg_len[1] = da / 2; seg_len[6] = da / 2;
    seg_len[2] = db / 2; seg_len[5] = db / 2;
    seg_len[3] = dz / 4; seg_len[4] = dz / 4; seg_len[7] = dz / 4;
    seg_len[0] = PER - da / 2 * 2 - db / 2 * 2 - dz / 4 * 3;
    which[0] = po; which[7] = po; which[1] = pa; which[6] = pa;
    which[2] = pb; which[5] = pb; which[3] = pc; which[4] = pc;
    k = 0;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < seg_len[s]; c++) begin
        exp_seg[k] = s; exp_st[k] = which[s]; k++;
      end
  endtask

  // one period; stop after n samples (restart test) and optionally scramble inputs mid-period
  task automatic run_period(input string req, input int za, input int zb,
      input logic [5:0] po, input logic [5:0] pa, input logic [5:0] pb, input logic [5:0] pc,
      input int n, input bit scramble, input bit adj);
    int first_bad, dur[8], sum, chg, worst;
    logic [5:0] st_at[8];
    build_exp(za, zb, po, pa, pb, pc);
    frac_a = 16'(za); frac_b = 16'(zb);
    vec_open = po; vec_a = pa; vec_b = pb; vec_close = pc;
    period_go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    period_go = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      obs_seg[i] = int'(seg_idx);
      obs_st[i]  = {lvl_r, lvl_y, lvl_b};
      if (scramble && i == 3) begin
        frac_a = 16'h7fff; frac_b = 16'h0123;
        vec_open = 6'b000000; vec_a = 6'b101010; vec_b = 6'b010101; vec_close = 6'b100001;
      end
    end
    first_bad = -1;
    for (int i = 0; i < n; i++)
      if (first_bad < 0 && (obs_seg[i] != exp_seg[i] || obs_st[i] != exp_st[i])) first_bad = i;
    check(first_bad < 0, req, "timeline mismatch at cycle (act seg / exp seg)",
          first_bad < 0 ? 0 : obs_seg[first_bad], first_bad < 0 ? 0 : exp_seg[first_bad]);
    if (n == PER) begin
      sum = 0;
      for (int s = 0; s < 8; s++) begin dur[s] = 0; st_at[s] = '0; end
      for (int i = 0; i < n; i++) begin dur[obs_seg[i]]++; st_at[obs_seg[i]] = obs_st[i]; end
      for (int s = 0; s < 8; s++) begin
        sum += dur[s];
        if (seg_len[s] == 0) check(dur[s] == 0, "R5", "empty segment shown", dur[s], 0);
      end
      check(dur[0] == seg_len[0], "R3", "remainder segment length", dur[0], seg_len[0]);
      check(dur[1] == dur[6] && dur[2] == dur[5] && dur[3] == dur[4] &&
            st_at[1] == st_at[6] && st_at[2] == st_at[5] && st_at[3] == st_at[4],
            "R10", "mirror symmetry (dur1 vs dur6)", dur[1], dur[6]);
      if (adj) begin
        worst = 0;
        for (int i = 1; i < n; i++) begin
          chg = 0;
          for (int p = 0; p < 3; p++)
            if (obs_st[i][2*p +: 2] != obs_st[i-1][2*p +: 2]) chg++;
          if (obs_seg[i] != obs_seg[i-1] && chg != 1) worst = chg;
          if (obs_seg[i] == obs_seg[i-1] && chg != 0) worst = chg;
        end
        check(worst == 0, "R10", "phases changed at a transition", worst, 1);
      end
    end
  endtask

  task automatic idle_hold();
    logic [5:0] last_st;
    int last_seg;
    bit ok;
    last_st = {lvl_r, lvl_y, lvl_b}; last_seg = int'(seg_idx);
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if ({lvl_r, lvl_y, lvl_b} != last_st || int'(seg_idx) != last_seg) ok = 1'b0;
    end
    check(ok && last_seg == 7, "R8", "hold after period (seg)", int'(seg_idx), 7);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check({lvl_r, lvl_y, lvl_b} == 6'd0, "R9", "levels in reset", int'({lvl_r, lvl_y, lvl_b}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(seg_idx == 3'd0 && {lvl_r, lvl_y, lvl_b} == 6'd0, "R9", "state after reset",
          int'(seg_idx), 0);
    // R1 R2 R4: typical sector, states 221 220 210 110
    run_period("R4", 9830, 13107, 6'b10_10_01, 6'b10_10_00, 6'b10_01_00, 6'b01_01_00, PER, 0, 1);
    // R10: neighbour sector, 210 replaced by 120, back to back
    run_period("R1", 8192, 16384, 6'b10_10_01, 6'b10_10_00, 6'b01_10_00, 6'b01_01_00, PER, 0, 1);
    // R3: odd dwells leave a remainder in segment 0
    run_period("R3", 7000, 11000, 6'b10_10_01, 6'b10_10_00, 6'b10_01_00, 6'b01_01_00, PER, 0, 1);
    // R5: zero redundant dwell
    run_period("R5", 16384, 16384, 6'b10_10_01, 6'b10_10_00, 6'b10_01_00, 6'b01_01_00, PER, 0, 0);
    // R5: zero first active dwell
    run_period("R5", 0, 20000, 6'b10_10_01, 6'b10_10_00, 6'b10_01_00, 6'b01_01_00, PER, 0, 0);
    // R2: fractions add to more than one, second one saturates
    run_period("R2", 29491, 29491, 6'b01_01_01, 6'b01_01_00, 6'b01_00_00, 6'b00_00_00, PER, 0, 0);
    // R6: inputs scrambled mid-period
    run_period("R6", 9830, 13107, 6'b10_10_01, 6'b10_10_00, 6'b10_01_00, 6'b01_01_00, PER, 1, 1);
    // R7: abandon after 9 cycles, restart with a different set
    run_period("R7", 9830, 13107, 6'b10_10_01, 6'b10_10_00, 6'b10_01_00, 6'b01_01_00, 9, 0, 0);
    run_period("R7", 4000, 6000, 6'b01_01_01, 6'b01_01_00, 6'b01_00_00, 6'b00_00_00, PER, 0, 1);
    idle_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 50000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule